// File: doc/BRIEF.md
# Fractional Baud Tick Generator

This block turns the system clock into a stream of single-cycle enable pulses at sixteen times a serial bit rate. That pulse is the oversampling tick that the transmit and receive bit timing run from. The divisor is the clock frequency divided by sixteen times the baud rate. It is given in two parts: a 16-bit whole part and a 6-bit fractional part in units of 1/64. The fractional setting is the fraction of the divisor multiplied by 64 and rounded to the nearest integer. For example, a 48 MHz clock at 115200 baud gives a whole part of 26 and a fractional part of 3.

A 6-bit accumulator adds the fractional setting once per tick period. Whenever that addition carries out, the period is one clock longer than the whole part. The long-run average period is therefore exact, and no special clock is needed. When the block is disabled, or when the whole part is zero, the counter and accumulator stay cleared and no ticks are produced.

Top module: `baud_tick_gen`

## Requirements
- R1: `tick` is high for exactly one clock per period. The clock count from one tick to the next is `div_int` plus a stretch bit of 0 or 1. Back-to-back ticks appear only when that count is 1.
- R2: The accumulator starts at 0 on enable. Each period first adds `div_frac` to it modulo 64, and the stretch bit of that period is the carry out of that 6-bit addition.
- R3: Any 64 consecutive tick-to-tick intervals add up to exactly 64*`div_int` + `div_frac` clocks.
- R4: After `enable` is first sampled high by a rising clock edge, the first tick is visible after the `div_int`-th such edge, counting that edge as the first.
- R5: While `div_int` is 0, no tick is produced.
- R6: One edge after `enable` is sampled low, `tick` is low and the internal state is cleared. A later enable restarts timing exactly as in R4.
- R7: With `div_frac` = 0, every interval is exactly `div_int` clocks.
- R8: With `div_int` = 26 and `div_frac` = 3, 64 intervals take 1667 clocks.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| enable | input | 1 | Run the generator; low clears the state |
| div_int | input | 16 | Whole part of the divisor; 0 is invalid |
| div_frac | input | 6 | Fractional part of the divisor in 1/64 units |
| tick | output | 1 | Single-cycle oversampling pulse |

## Verification
The counter-bound assertion assumes the divisor does not change in the same cycle that it is checked. The accumulator and timing checks assume the divisor is held constant while the generator runs. The bench therefore changes `div_int` and `div_frac` only while `enable` is low. It drives them at the falling edge, together with `enable`, for every random and directed case. The random divisors are kept small, so that each case covers more than 64 intervals within the run length. Larger whole parts are exercised in short directed runs.

// File: rtl/baud_tick_pkg.sv
package baud_tick_pkg;
    localparam int DEF_INT_W  = 16;
    localparam int DEF_FRAC_W = 6;

    typedef struct packed {
        logic tick;
    } tick_state_t;
endpackage

// File: rtl/baud_frac_accum.sv
module baud_frac_accum #(
    parameter int FRAC_W = baud_tick_pkg::DEF_FRAC_W
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              clear,
    input  logic              advance,
    input  logic [FRAC_W-1:0] frac,
    output logic [FRAC_W-1:0] acc,
    output logic              carry
);
    typedef struct packed {
        logic [FRAC_W-1:0] acc;
    } acc_state_t;

    acc_state_t st_d, st_q;
    logic [FRAC_W:0] sum_w;

    always_comb begin
        sum_w = {1'b0, st_q.acc} + {1'b0, frac};
        st_d  = st_q;
        if (clear) begin
            st_d.acc = '0;
        end else if (advance) begin
            st_d.acc = sum_w[FRAC_W-1:0];
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            st_q <= '0;
        end else begin
            st_q <= st_d;
        end
    end

    assign acc   = st_q.acc;
    assign carry = sum_w[FRAC_W];

    // R2: the accumulator only moves on a period boundary or a clear
    assert_acc_hold_R2: assert property (@(posedge clk) disable iff (!rst_n)
        (!clear && !advance) |=> $stable(acc));
endmodule

// File: rtl/baud_period_cnt.sv
module baud_period_cnt #(
    parameter int INT_W = baud_tick_pkg::DEF_INT_W
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             clear,
    input  logic [INT_W:0]   limit,
    output logic             wrap,
    output logic [INT_W-1:0] cnt
);
    typedef struct packed {
        logic [INT_W-1:0] cnt;
    } cnt_state_t;

    cnt_state_t st_d, st_q;
    logic [INT_W:0] next_w;

    always_comb begin
        next_w = {1'b0, st_q.cnt} + {{INT_W{1'b0}}, 1'b1};
        wrap   = !clear && (next_w >= limit);
        st_d   = st_q;
        if (clear || wrap) begin
            st_d.cnt = '0;
        end else begin
            st_d.cnt = next_w[INT_W-1:0];
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            st_q <= '0;
        end else begin
            st_q <= st_d;
        end
    end

    assign cnt = st_q.cnt;

    // R1: with a steady period length the count never reaches the length
    assert_cnt_below_limit_R1: assert property (@(posedge clk) disable iff (!rst_n)
        (!clear && !$past(clear) && $stable(limit)) |-> ({1'b0, cnt} < limit));
endmodule

// File: rtl/baud_tick_gen.sv
module baud_tick_gen #(
    parameter int INT_W  = baud_tick_pkg::DEF_INT_W,
    parameter int FRAC_W = baud_tick_pkg::DEF_FRAC_W
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              enable,
    input  logic [INT_W-1:0]  div_int,
    input  logic [FRAC_W-1:0] div_frac,
    output logic              tick
);
    import baud_tick_pkg::*;

    localparam int LIM_W = INT_W + 1;

    tick_state_t       st_d, st_q;
    logic              run_ok;
    logic              clear;
    logic              stretch;
    logic              wrap;
    logic [LIM_W-1:0]  limit;
    logic [FRAC_W-1:0] acc;
    logic [INT_W-1:0]  cnt;

    baud_frac_accum #(.FRAC_W(FRAC_W)) i_accum (
        .clk     (clk),
        .rst_n   (rst_n),
        .clear   (clear),
        .advance (wrap),
        .frac    (div_frac),
        .acc     (acc),
        .carry   (stretch)
    );

    baud_period_cnt #(.INT_W(INT_W)) i_cnt (
        .clk   (clk),
        .rst_n (rst_n),
        .clear (clear),
        .limit (limit),
        .wrap  (wrap),
        .cnt   (cnt)
    );

    always_comb begin
        run_ok    = enable && (div_int != '0);
        clear     = !run_ok;
        limit     = {1'b0, div_int} + {{INT_W{1'b0}}, stretch};
        st_d      = st_q;
        st_d.tick = run_ok && wrap;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            st_q <= '0;
        end else begin
            st_q <= st_d;
        end
    end

    assign tick = st_q.tick;

    // R5: a zero whole part never produces a tick
    assert_zero_div_silent_R5: assert property (@(posedge clk) disable iff (!rst_n)
        (enable && div_int == '0) |=> !tick);

    // R6: disabling drops the tick and clears both state holders
    assert_idle_quiet_R6: assert property (@(posedge clk) disable iff (!rst_n)
        !enable |=> (!tick && cnt == '0 && acc == '0));

    // R1: a tick is followed by another only when the period is one clock
    assert_single_pulse_R1: assert property (@(posedge clk) disable iff (!rst_n)
        (tick && enable && $stable(div_int) && div_int > 16'd2) |=> !tick);
endmodule

// File: tb/test_baud_tick_gen.sv
module test_baud_tick_gen;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        enable = 1'b0;
    logic [15:0] div_int = 16'd0;
    logic [5:0]  div_frac = 6'd0;
    logic        tick;

    int n_checks = 0;
    int n_fails  = 0;
    bit done     = 1'b0;

    always #2 clk = ~clk;

    baud_tick_gen i_baud_tick_gen (
        .clk      (clk),
        .rst_n    (rst_n),
        .enable   (enable),
        .div_int  (div_int),
        .div_frac (div_frac),
        .tick     (tick)
    );

    task automatic check(input bit ok, input string req, input int act, input int exp);
        n_checks++;
        if (!ok) begin
            n_fails++;
            $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
        end
    endtask

    // Interval length per the fractional accumulation rule
    function automatic int period_len(input int i_part, input int f_part, inout int acc_m);
        int s = acc_m + f_part;
        acc_m = s % 64;
        return i_part + ((s >= 64) ? 1 : 0);
    endfunction

    task automatic run_case(input int i_part, input int f_part, input int n_ticks, input string req);
        int acc_m = 0;
        int cyc = 0;
        int got = 0;
        int t_first = 0;
        int t_last = 0;
        int next_exp;
        @(negedge clk);
        enable = 1'b0;
        @(negedge clk);
        check(tick == 1'b0, "R6 tick low after disable", tick, 0);
        div_int  = 16'(i_part);
        div_frac = 6'(f_part);
        enable   = 1'b1;
        next_exp = period_len(i_part, f_part, acc_m);
        while (got < n_ticks) begin
            @(negedge clk);
            cyc++;
            if (tick || cyc == next_exp) begin
                if (got == 0)
                    check(tick && cyc == next_exp, {"R4 first tick ", req}, cyc, next_exp);
                else
                    check(tick && cyc == next_exp, {"R1 R2 interval ", req}, cyc, next_exp);
                if (!(tick && cyc == next_exp)) break;
                got++;
                if (got == 1)  t_first = cyc;
                if (got == 65) t_last = cyc;
                next_exp += period_len(i_part, f_part, acc_m);
            end
        end
        if (n_ticks >= 65 && got >= 65)
            check(t_last - t_first == 64 * i_part + f_part, {"R3 64-interval sum ", req},
                  t_last - t_first, 64 * i_part + f_part);
    endtask

    initial begin
        repeat (150000) @(posedge clk);
        if (!done) begin
            n_checks++;
            n_fails++;
            $display("FAIL watchdog actual=timeout expected=finish");
            $display("%0d/%0d checks passed", n_checks - n_fails, n_checks);
            $finish;
        end
    end

    initial begin
        int seen;
        void'($urandom(32'd4242));
        repeat (3) @(negedge clk);
        check(tick == 1'b0, "R6 reset state", tick, 0);
        rst_n = 1'b1;

        // R8: 48 MHz / 115200 example
        run_case(26, 3, 66, "R8 26+3/64");
        // R7: integer-only dividers
        run_case(1, 0, 70, "R7 1+0");
        run_case(2, 0, 70, "R7 2+0");
        run_case(13, 0, 66, "R7 13+0");
        // fractional corners
        run_case(1, 63, 70, "R2 1+63");
        run_case(1, 32, 70, "R2 1+32");
        run_case(3, 1, 66, "R2 3+1");
        run_case(300, 17, 66, "R3 300+17");
        run_case(5000, 63, 3, "R1 5000+63");

        // R6: stop mid-period, check silence, then restart timing
        run_case(20, 40, 4, "R6 pre-stop");
        @(negedge clk);
        enable = 1'b0;
        seen = 0;
        repeat (60) begin
            @(negedge clk);
            if (tick) seen++;
        end
        check(seen == 0, "R6 no tick while disabled", seen, 0);
        run_case(20, 40, 66, "R6 restart");

        // R5: zero whole part produces nothing
        @(negedge clk);
        div_int  = 16'd0;
        div_frac = 6'd37;
        enable   = 1'b1;
        seen = 0;
        repeat (300) begin
            @(negedge clk);
            if (tick) seen++;
        end
        check(seen == 0, "R5 zero divisor silent", seen, 0);

        // random divisors
        for (int k = 0; k < 10; k++) begin
            int ri = 1 + int'($urandom % 40);
            int rf = int'($urandom % 64);
            run_case(ri, rf, 66, "R3 random");
        end

        done = 1'b1;
        $display("%0d/%0d checks passed", n_checks - n_fails, n_checks);
        $finish;
    end
endmodule